// File: doc/BRIEF.md
# Joypad Interrupt Two-Sample Qualifier

This block decides when button activity should become a joypad interrupt request. It watches a group of active-low button lines that have already been synchronized to the system clock. A low on any line counts as activity. The block does not use an edge detector or a continuous-low debounce. It samples the combined line once per machine cycle, on sampling edges spaced a fixed number of clocks apart, and raises a request only when two consecutive sampling edges both see the line low.

Whatever the line does between those two edges has no effect. A short glitch that lands on only one sampling edge is rejected. A second low that arrives one clock too early or too late is also rejected, because it falls between sampling edges. When two samples qualify, the block drives a one-clock request pulse to the interrupt controller. If the line then stays low, no further request follows. A fresh request needs the line to be seen high at a sampling edge first, and then low at two more.

Top module: `joypad_pair_qualifier`

## Requirements
- R1: The lines are merged into one active-low activity signal. A low on any single line, with every other line high, counts as low.
- R2: Sampling edges are the first rising clock edge after reset is released, and every `SAMPLE_GAP` clocks after that (default 4). Lows at any other edge are never sampled.
- R3: A request is raised exactly when the merged signal is low at two consecutive sampling edges and was high at the sampling edge before them. Each sampling edge after reset counts as high until it has actually sampled the line.
- R4: The line's value at the clock edges between two sampling edges has no effect. A line that is high, or toggling, at all of them still qualifies.
- R5: If the second low is moved one clock earlier or later than the second sampling edge, no request is raised.
- R6: A single low pulse one clock wide, on one sampling edge, raises no request.
- R7: A request is a pulse on `irqPulse` that is exactly one clock wide. It is asserted in the clock cycle that follows the qualifying second sampling edge.
- R8: A line held low for many machine cycles produces exactly one request.
- R9: While `rstN` is low, `irqPulse` is 0. Reset discards the sampled history, so a low seen before reset cannot pair with a low seen after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyLines | input | NUM_LINES (4) | Synchronized active-low button lines |
| irqPulse | output | 1 | One-clock joypad interrupt request |

## Verification
The hardest case to reach is a request made from two single-clock lows that sit exactly one sampling period apart. The line must be high or toggling at every edge in between, and the stimulus must also cover its near misses one clock either side. The bench follows the clock count since reset, so it knows which edge is the next sampling edge. It then places single-clock lows at chosen offsets from that edge and toggles the line in between. A behavioural model keeps a queue of past samples and predicts the output, and the output is compared with it on every clock. Separate pulse counts per scenario check the expected number of requests.

// File: rtl/joypad_qual_pkg.sv
package joypad_qual_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic sampleStb;   // this rising edge is a sampling edge
  } qualStrobes_t;

endpackage

// File: rtl/joypad_pair_ctrl.sv
module joypad_pair_ctrl
  import joypad_qual_pkg::*;
#(
  parameter int SAMPLE_GAP = 4
) (
  input  logic         clk,
  input  logic         rstN,
  output qualStrobes_t strobes
);

  localparam int PHASE_W = (SAMPLE_GAP > 2) ? $clog2(SAMPLE_GAP) : 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(SAMPLE_GAP - 1);

  logic [PHASE_W-1:0] phase;

  // Phase zero marks a sampling edge; it restarts at zero after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (phase == LAST_PHASE) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobes.sampleStb = (phase == '0);
  end

endmodule

// File: rtl/joypad_pair_datapath.sv
module joypad_pair_datapath
  import joypad_qual_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] keyLines,
  input  qualStrobes_t         strobes,
  output logic                 irqPulse
);

  localparam int HIST_DEPTH = 2;

  logic                  anyLow;
  logic [HIST_DEPTH-1:0] histLow;   // [0] newest sample, [1] the one before
  logic                  irqReg;

  // Merge the active-low lines: any low line makes the group low.
  assign anyLow = ~(&keyLines);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histLow <= '0;
      irqReg  <= 1'b0;
    end else begin
      irqReg <= 1'b0;
      if (strobes.sampleStb) begin
        irqReg  <= anyLow & histLow[0] & ~histLow[1];
        histLow <= {histLow[HIST_DEPTH-2:0], anyLow};
      end
    end
  end

  assign irqPulse = irqReg;

endmodule

// File: rtl/joypad_pair_qualifier.sv
module joypad_pair_qualifier
  import joypad_qual_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int SAMPLE_GAP = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] keyLines,
  output logic                 irqPulse
);

  qualStrobes_t strobes;
  logic         sampleStb;

  joypad_pair_ctrl #(
    .SAMPLE_GAP(SAMPLE_GAP)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes)
  );

  joypad_pair_datapath #(
    .NUM_LINES(NUM_LINES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .keyLines(keyLines),
    .strobes (strobes),
    .irqPulse(irqPulse)
  );

  assign sampleStb = strobes.sampleStb;

endmodule

// File: rtl/joypad_pair_qualifier_checker.sv
module joypad_pair_qualifier_checker #(
  parameter int NUM_LINES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] keyLines,
  input logic                 irqPulse,
  input logic                 sampleStb
);

  // R7: a request never lasts more than one clock
  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R2: requests only follow a sampling edge
  assert_after_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(sampleStb));

  // R2: sampling edges are never adjacent
  assert_sample_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  // R3: the edge that produced a request saw the merged line low
  assert_low_at_second_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(~(&keyLines)));

  // R9: no request in the first clock after reset is released
  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !irqPulse);

endmodule

bind joypad_pair_qualifier joypad_pair_qualifier_checker #(
  .NUM_LINES(NUM_LINES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .keyLines (keyLines),
  .irqPulse (irqPulse),
  .sampleStb(sampleStb)
);

// File: tb/joypad_pair_qualifier_bench.sv
`timescale 1ns/1ps
module joypad_pair_qualifier_bench;

  localparam int LINES = 4;
  localparam int GAP   = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LINES-1:0] keyLines = '1;
  logic             irqPulse;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    edgeCount = 0;      // rising edges processed since reset release
  int    pulseCount = 0;
  int    cycleCount = 0;
  bit    finished = 0;
  bit    expIrq = 0;
  bit    sampleQ[$];         // behavioural record of sampled lows, newest first
  string curTag = "R9";

  always #10 clk = ~clk;

  joypad_pair_qualifier #(.NUM_LINES(LINES), .SAMPLE_GAP(GAP)) u_joypad_pair_qualifier (
    .clk(clk), .rstN(rstN), .keyLines(keyLines), .irqPulse(irqPulse)
  );

  // Reference model, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rstN) begin
      edgeCount = 0;
      sampleQ.delete();
      expIrq = 0;
    end else begin
      if (edgeCount % GAP == 0) begin
        bit lowNow;
        bit prev1;
        bit prev2;
        lowNow = (keyLines != '1);
        prev1 = (sampleQ.size() > 0) ? sampleQ[0] : 1'b0;
        prev2 = (sampleQ.size() > 1) ? sampleQ[1] : 1'b0;
        expIrq = lowNow && prev1 && !prev2;
        sampleQ.push_front(lowNow);
        if (sampleQ.size() > 4) void'(sampleQ.pop_back());
      end else begin
        expIrq = 0;
      end
      edgeCount++;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    cycleCount++;
    if (!finished) begin
      testsRun++;
      if (irqPulse !== expIrq) begin
        testsFailed++;
        $display("FAIL %s: irqPulse actual=%b expected=%b at edge %0d", curTag, irqPulse, expIrq, edgeCount);
      end
      if (irqPulse === 1'b1) pulseCount++;
    end
    if (cycleCount > 100000 && !finished) begin
      finished = 1;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic idle(input int n);
    keyLines = '1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic alignToSample();
    while (edgeCount % GAP != 0) @(negedge clk);
  endtask

  task automatic lowOneClock(input logic [LINES-1:0] mask);
    keyLines = ~mask;
    @(negedge clk);
    keyLines = '1;
  endtask

  task automatic checkCount(input string tag, input int got, input int want);
    testsRun++;
    if (got != want) begin
      testsFailed++;
      $display("FAIL %s: pulse count actual=%0d expected=%0d", tag, got, want);
    end
  endtask

  // Two one-clock lows; the second is placed GAP+delta clocks after the first.
  task automatic pairTest(input string tag, input logic [LINES-1:0] mask,
                          input int startOff, input int delta, input int want);
    int start;
    curTag = tag;
    idle(3 * GAP);
    alignToSample();
    idle(startOff);
    start = pulseCount;
    lowOneClock(mask);
    idle(GAP - 1 + delta);
    lowOneClock(mask);
    idle(3 * GAP);
    checkCount(tag, pulseCount - start, want);
  endtask

  initial begin
    int start;
    repeat (3) @(negedge clk);
    testsRun++;
    if (irqPulse !== 1'b0) begin
      testsFailed++;
      $display("FAIL R9: irqPulse in reset actual=%b expected=0", irqPulse);
    end
    rstN = 1'b1;

    // R1/R3: each line alone qualifies with exact spacing
    for (int b = 0; b < LINES; b++) pairTest("R1", LINES'(1) << b, 0, 0, 1);
    pairTest("R3", 4'b0101, 0, 0, 1);

    // R5: second low one clock early or late
    pairTest("R5", 4'b0001, 0, -1, 0);
    pairTest("R5", 4'b0010, 0, 1, 0);

    // R2: same spacing but off the sampling phase
    pairTest("R2", 4'b0100, 1, 0, 0);
    pairTest("R2", 4'b1000, 2, 0, 0);

    // R6: single short low on a sampling edge
    curTag = "R6";
    idle(3 * GAP); alignToSample();
    start = pulseCount;
    lowOneClock(4'b0001);
    idle(4 * GAP);
    checkCount("R6", pulseCount - start, 0);

    // R4: line toggles between the two sampling edges
    curTag = "R4";
    idle(3 * GAP); alignToSample();
    start = pulseCount;
    lowOneClock(4'b0010);
    for (int i = 0; i < GAP - 1; i++) begin
      keyLines = (i % 2 == 0) ? 4'b1111 : 4'b1101;
      @(negedge clk);
    end
    lowOneClock(4'b0010);
    idle(3 * GAP);
    checkCount("R4", pulseCount - start, 1);

    // R8/R7: long hold gives a single one-clock pulse
    curTag = "R8";
    idle(3 * GAP); alignToSample();
    start = pulseCount;
    keyLines = 4'b1011;
    repeat (8 * GAP) @(negedge clk);
    idle(3 * GAP);
    checkCount("R8", pulseCount - start, 1);
    checkCount("R7", pulseCount - start, 1);

    // R9: low before reset does not pair with low after reset
    curTag = "R9";
    idle(3 * GAP); alignToSample();
    start = pulseCount;
    lowOneClock(4'b0001);
    idle(GAP - 2);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    testsRun++;
    if (irqPulse !== 1'b0) begin
      testsFailed++;
      $display("FAIL R9: irqPulse during reset actual=%b expected=0", irqPulse);
    end
    rstN = 1'b1;
    alignToSample();
    lowOneClock(4'b0001);
    idle(4 * GAP);
    checkCount("R9", pulseCount - start, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule